// File: doc/BRIEF.md
# Sliced Text Packet Formatter

This block packs the text bytes decoded from one video line into a framed byte stream for an 8-bit video output port. Upstream logic pushes the payload bytes of a line with a valid/last handshake. The block stores them until the last byte arrives, then sends a complete packet on consecutive clock cycles. A packet has a three-byte start preamble, a programmable stream tag, a count of 32-bit words, two identification bytes that carry field and line information, the payload, zero padding and a closing marker byte.

Every header and payload byte carries its own parity bits. Two byte formats are used. A six-bit format ("even-6") holds data in bits 5..0, bit 6 is the even parity of those six bits and bit 7 is the complement of bit 6. A seven-bit format ("odd-7") holds data in bits 6..0 and bit 7 makes the number of ones in the byte odd. Each payload byte is sent as two even-6 bytes, low nibble first. The word count covers everything from the first identification byte up to the closing marker, and it is rounded up to whole 32-bit words. Storage holds enough bytes for the largest count allowed. The field, line, type and tag inputs are sampled when the last payload byte is accepted, so they may change while the packet is being sent.

Top module: `slice_pkt_packer`

## Requirements
- R1: A packet opens with the bytes 00h, FFh, FFh, with `out_sop` high on the 00h byte only. The fourth byte is the even-6 encoding of `stream_tag`.
- R2: The even-6 encoding of a 6-bit value v is {~p, p, v}, where p is the XOR of the bits of v. Bits 6..0 of such a byte therefore hold an even number of ones.
- R3: The fifth byte is the even-6 encoding of the word count DC = ceil((2 + 2·N) / 4), where N is the number of payload bytes kept. DC is held within 1..11.
- R4: The sixth byte is the odd-7 encoding of {field_id, line_no[8:3]}, with field_id in bit 6. Odd-7 of a 7-bit value w is {~^w, w}.
- R5: The seventh byte is the odd-7 encoding of {line_no[2:0], data_kind[3:0]}.
- R6: Each kept payload byte b is sent as even-6({b[3:0], 2'b11}) and then even-6({b[7:4], 2'b11}), in the order the bytes were received.
- R7: After the payload, 00h bytes are inserted until the number of bytes from the sixth byte onward equals 4·DC.
- R8: The packet ends with the marker byte (parameter END_BYTE, default 9Dh) with `out_eop` high on it. A packet is 6 + 4·DC bytes long.
- R9: `in_ready` is low from the cycle after the last payload byte is accepted until the cycle after the marker byte. Input offered in that window is ignored and affects neither the current packet nor the next one.
- R10: Payload bytes past the 21st in one line are dropped. Such a packet carries DC = 11 and holds only the first 21 bytes.
- R11: field_id, line_no, data_kind and stream_tag are taken in the cycle the last payload byte is accepted. Changes to them afterwards do not alter the packet.
- R12: A synchronous active-high `rst` leaves `out_valid` low and `in_ready` high in the next cycle, even in the middle of a packet. It also discards any stored payload.
- R13: The first preamble byte appears two clock edges after the edge that accepts the last payload byte. All packet bytes follow on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Payload byte offered |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Marks the final payload byte of the line |
| in_ready | output | 1 | Block accepts payload bytes |
| field_id | input | 1 | Field identity (0 first field, 1 second field) |
| line_no | input | 9 | Video line number |
| data_kind | input | 4 | Text data type code |
| stream_tag | input | 6 | Software-programmed packet tag |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | First byte of a packet |
| out_eop | output | 1 | Marker byte closing a packet |

## Verification
The hardest condition to reach from the ports is input offered while a packet is being sent. It must not leak into the buffer that the next packet is built from. The stimulus raises `in_valid` and `in_last` with a foreign byte during emission and drops them before the marker. It then checks that the current packet and the next packet are both exact. The payload length is also pushed past the 21-byte capacity so that the clamp and the dropping take effect. A reset is applied in the middle of a packet, followed by a one-byte packet whose word count reveals any payload left over from before the reset.

// File: rtl/slice_pkt_pkg.sv
package slice_pkt_pkg;

    // Sideband fields taken together with the last payload byte.
    typedef struct packed {
        logic       fid;
        logic [8:0] line;
        logic [3:0] kind;
        logic [5:0] tag;
    } side_t;

    // Six data bits, even parity in bit 6, its complement in bit 7.
    function automatic logic [7:0] enc_even6(input logic [5:0] v);
        logic p;
        p = ^v;
        return {~p, p, v};
    endfunction

    // Seven data bits, bit 7 makes the total count of ones odd.
    function automatic logic [7:0] enc_odd7(input logic [6:0] w);
        return {~(^w), w};
    endfunction

    // One payload nibble in bits 5..2, bits 1..0 fixed to ones.
    function automatic logic [7:0] enc_nibble(input logic [3:0] n);
        return enc_even6({n, 2'b11});
    endfunction

endpackage

// File: rtl/slice_pkt_buffer.sv
module slice_pkt_buffer #(
    parameter int MAX_BYTES = 21,
    parameter int CNT_W     = $clog2(MAX_BYTES + 1),
    parameter int IDX_W     = $clog2(MAX_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             clr,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    output logic [CNT_W-1:0] count
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } buf_state_t;

    buf_state_t st_d, st_q;
    logic [7:0] mem_d [MAX_BYTES];
    logic [7:0] mem_q [MAX_BYTES];
    logic       room;

    always_comb begin
        st_d  = st_q;
        mem_d = mem_q;
        room  = (int'(st_q.cnt) < MAX_BYTES);
        if (clr) begin
            st_d.cnt = '0;
        end else if (wr_en && room) begin
            for (int i = 0; i < MAX_BYTES; i++) begin
                if (int'(st_q.cnt) == i) begin
                    mem_d[i] = wr_data;
                end
            end
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
        mem_q <= mem_d;
    end

    always_comb begin
        if (int'(rd_idx) < MAX_BYTES) begin
            rd_data = mem_q[rd_idx];
        end else begin
            rd_data = 8'h00;
        end
    end

    assign count = st_q.cnt;

endmodule

// File: rtl/slice_pkt_header.sv
module slice_pkt_header
    import slice_pkt_pkg::*;
#(
    parameter int MAX_DC = 11,
    parameter int CNT_W  = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap,
    input  side_t            side_in,
    input  logic [CNT_W-1:0] count,
    output logic [5:0]       dc_val,
    output logic [7:0]       tag_byte,
    output logic [7:0]       dc_byte,
    output logic [7:0]       id1_byte,
    output logic [7:0]       id2_byte
);

    typedef struct packed {
        side_t side;
    } hdr_state_t;

    hdr_state_t st_d, st_q;
    logic [7:0] dc_raw;

    always_comb begin
        st_d = st_q;
        if (cap) begin
            st_d.side = side_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Bytes from the first identification byte: 2 + two per payload byte.
    always_comb begin
        dc_raw = 8'((2 * int'(count) + 2 + 3) / 4);
        if (dc_raw < 8'd1) begin
            dc_raw = 8'd1;
        end else if (dc_raw > 8'(MAX_DC)) begin
            dc_raw = 8'(MAX_DC);
        end
        dc_val = 6'(dc_raw);
    end

    assign tag_byte = enc_even6(st_q.side.tag);
    assign dc_byte  = enc_even6(dc_val);
    assign id1_byte = enc_odd7({st_q.side.fid, st_q.side.line[8:3]});
    assign id2_byte = enc_odd7({st_q.side.line[2:0], st_q.side.kind});

endmodule

// File: rtl/slice_pkt_seq.sv
module slice_pkt_seq
    import slice_pkt_pkg::*;
#(
    parameter logic [7:0] END_BYTE = 8'h9D,
    parameter int         MAX_DC   = 11,
    parameter int         CNT_W    = 5,
    parameter int         IDX_W    = 5,
    parameter int         STEP_W   = $clog2(6 + 4 * MAX_DC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] count,
    input  logic [5:0]       dc_val,
    input  logic [7:0]       tag_byte,
    input  logic [7:0]       dc_byte,
    input  logic [7:0]       id1_byte,
    input  logic [7:0]       id2_byte,
    input  logic [7:0]       rd_data,
    output logic [IDX_W-1:0] rd_idx,
    output logic             busy,
    output logic             clr,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_sop,
    output logic             out_eop
);

    // Fixed step positions inside a packet.
    localparam int S_TAG  = 3;
    localparam int S_DC   = 4;
    localparam int S_ID1  = 5;
    localparam int S_ID2  = 6;
    localparam int S_PAY  = 7;

    typedef struct packed {
        logic              busy;
        logic [STEP_W-1:0] step;
        logic              valid;
        logic [7:0]        data;
        logic              sop;
        logic              eop;
    } seq_state_t;

    seq_state_t        st_d, st_q;
    logic [STEP_W-1:0] end_step;
    logic [STEP_W-1:0] pay_end;
    logic [STEP_W-1:0] rel;

    always_comb begin
        end_step = STEP_W'(S_ID1 + 4 * int'(dc_val));
        pay_end  = STEP_W'(S_PAY + 2 * int'(count));
        rel      = st_q.step - STEP_W'(S_PAY);
        rd_idx   = IDX_W'(rel >> 1);
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.sop   = 1'b0;
        st_d.eop   = 1'b0;
        st_d.data  = 8'h00;
        clr        = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.step = '0;
            end
        end else if (st_q.step > end_step) begin
            st_d.busy = 1'b0;
            st_d.step = '0;
            clr       = 1'b1;
        end else begin
            st_d.valid = 1'b1;
            st_d.step  = st_q.step + 1'b1;
            if (st_q.step == '0) begin
                st_d.data = 8'h00;
                st_d.sop  = 1'b1;
            end else if (int'(st_q.step) < S_TAG) begin
                st_d.data = 8'hFF;
            end else if (int'(st_q.step) == S_TAG) begin
                st_d.data = tag_byte;
            end else if (int'(st_q.step) == S_DC) begin
                st_d.data = dc_byte;
            end else if (int'(st_q.step) == S_ID1) begin
                st_d.data = id1_byte;
            end else if (int'(st_q.step) == S_ID2) begin
                st_d.data = id2_byte;
            end else if (st_q.step < pay_end) begin
                if (!rel[0]) begin
                    st_d.data = enc_nibble(rd_data[3:0]);
                end else begin
                    st_d.data = enc_nibble(rd_data[7:4]);
                end
            end else if (st_q.step < end_step) begin
                st_d.data = 8'h00;
            end else begin
                st_d.data = END_BYTE;
                st_d.eop  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = st_q.busy;
    assign out_valid = st_q.valid;
    assign out_data  = st_q.data;
    assign out_sop   = st_q.sop;
    assign out_eop   = st_q.eop;

endmodule

// File: rtl/slice_pkt_packer.sv
module slice_pkt_packer
    import slice_pkt_pkg::*;
#(
    parameter int         MAX_DC   = 11,
    parameter logic [7:0] END_BYTE = 8'h9D
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_last,
    output logic       in_ready,
    input  logic       field_id,
    input  logic [8:0] line_no,
    input  logic [3:0] data_kind,
    input  logic [5:0] stream_tag,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_sop,
    output logic       out_eop
);

    // Largest payload whose nibble bytes plus two ID bytes fit MAX_DC words.
    localparam int MAX_BYTES = 2 * MAX_DC - 1;
    localparam int CNT_W     = $clog2(MAX_BYTES + 1);
    localparam int IDX_W     = $clog2(MAX_BYTES);

    logic             busy;
    logic             clr;
    logic             accept;
    logic             start;
    logic [IDX_W-1:0] rd_idx;
    logic [7:0]       rd_data;
    logic [CNT_W-1:0] count;
    logic [5:0]       dc_val;
    logic [7:0]       tag_byte;
    logic [7:0]       dc_byte;
    logic [7:0]       id1_byte;
    logic [7:0]       id2_byte;
    side_t            side_in;

    assign in_ready = ~busy;
    assign accept   = in_valid & ~busy;
    assign start    = accept & in_last;

    always_comb begin
        side_in.fid  = field_id;
        side_in.line = line_no;
        side_in.kind = data_kind;
        side_in.tag  = stream_tag;
    end

    slice_pkt_buffer #(
        .MAX_BYTES (MAX_BYTES),
        .CNT_W     (CNT_W),
        .IDX_W     (IDX_W)
    ) u_buf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (accept),
        .wr_data (in_data),
        .clr     (clr),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .count   (count)
    );

    slice_pkt_header #(
        .MAX_DC (MAX_DC),
        .CNT_W  (CNT_W)
    ) u_hdr (
        .clk      (clk),
        .rst      (rst),
        .cap      (start),
        .side_in  (side_in),
        .count    (count),
        .dc_val   (dc_val),
        .tag_byte (tag_byte),
        .dc_byte  (dc_byte),
        .id1_byte (id1_byte),
        .id2_byte (id2_byte)
    );

    slice_pkt_seq #(
        .END_BYTE (END_BYTE),
        .MAX_DC   (MAX_DC),
        .CNT_W    (CNT_W),
        .IDX_W    (IDX_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .count     (count),
        .dc_val    (dc_val),
        .tag_byte  (tag_byte),
        .dc_byte   (dc_byte),
        .id1_byte  (id1_byte),
        .id2_byte  (id2_byte),
        .rd_data   (rd_data),
        .rd_idx    (rd_idx),
        .busy      (busy),
        .clr       (clr),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_sop   (out_sop),
        .out_eop   (out_eop)
    );

endmodule

// File: rtl/slice_pkt_packer_chk.sv
module slice_pkt_packer_chk #(
    parameter logic [7:0] END_BYTE = 8'h9D
) (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_last,
    input logic       in_ready,
    input logic       out_valid,
    input logic [7:0] out_data,
    input logic       out_sop,
    input logic       out_eop
);

    logic armed_q;

    always_ff @(posedge clk) begin
        armed_q <= 1'b1;
    end

    assert_no_input_while_sending_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    assert_sop_on_zero_R1: assert property (@(posedge clk) disable iff (rst)
        out_sop |-> (out_valid && out_data == 8'h00));

    assert_ff_after_sop_R1: assert property (@(posedge clk) disable iff (rst)
        out_sop |=> (out_valid && out_data == 8'hFF && !out_sop));

    assert_eop_marker_R8: assert property (@(posedge clk) disable iff (rst)
        out_eop |-> (out_valid && out_data == END_BYTE));

    assert_gapless_R13: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_eop) |=> out_valid);

    assert_start_latency_R13: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_last) |-> ##2 (out_sop && out_valid));

    assert_idle_after_reset_R12: assert property (@(posedge clk)
        (armed_q && $past(rst)) |-> (!out_valid && in_ready));

endmodule

bind slice_pkt_packer slice_pkt_packer_chk #(.END_BYTE(END_BYTE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_sop   (out_sop),
    .out_eop   (out_eop)
);

// File: tb/slice_pkt_packer_test.sv
`timescale 1ns/1ps
module slice_pkt_packer_test;

    localparam logic [7:0] EOD   = 8'h9D;
    localparam int         KEEP  = 21;

    // {len[39:32], seed[31:24], line[23:15], kind[14:11], fid[10], tag[9:4], 4'h0}
    localparam logic [39:0] VECS [0:7] = '{
        {8'd1,  8'h3C, 9'd0,   4'h0, 1'b0, 6'h00, 4'h0},
        {8'd2,  8'hA7, 9'd511, 4'hF, 1'b1, 6'h3F, 4'h0},
        {8'd3,  8'h11, 9'd21,  4'h5, 1'b0, 6'h15, 4'h0},
        {8'd4,  8'hF0, 9'd300, 4'hA, 1'b1, 6'h2A, 4'h0},
        {8'd10, 8'h5E, 9'd257, 4'h3, 1'b0, 6'h01, 4'h0},
        {8'd20, 8'h80, 9'd22,  4'h7, 1'b1, 6'h20, 4'h0},
        {8'd21, 8'hC9, 9'd335, 4'hC, 1'b0, 6'h0E, 4'h0},
        {8'd25, 8'h02, 9'd7,   4'h9, 1'b1, 6'h33, 4'h0}
    };

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic [7:0] in_data;
    logic       in_last;
    logic       in_ready;
    logic       field_id;
    logic [8:0] line_no;
    logic [3:0] data_kind;
    logic [5:0] stream_tag;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_sop;
    logic       out_eop;

    int         checks = 0;
    int         fails  = 0;
    bit         finished = 1'b0;
    logic [7:0] cap [0:63];
    int         cap_n = 0;
    bit         eop_seen = 1'b0;
    logic [7:0] expb [0:63];
    int         exp_n = 0;
    int         exp_pay = 0;

    always #2 clk = ~clk;

    slice_pkt_packer uut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_last    (in_last),
        .in_ready   (in_ready),
        .field_id   (field_id),
        .line_no    (line_no),
        .data_kind  (data_kind),
        .stream_tag (stream_tag),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_sop    (out_sop),
        .out_eop    (out_eop)
    );

    always @(negedge clk) begin
        if (out_valid) begin
            if (cap_n < 64) cap[cap_n] = out_data;
            cap_n = cap_n + 1;
            if (out_eop) eop_seen = 1'b1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R2: even-6 built by counting ones
    function automatic logic [7:0] m_even6(input logic [5:0] v);
        int ones;
        logic b6;
        ones = 0;
        for (int i = 0; i < 6; i++) ones += int'(v[i]);
        b6 = (ones % 2) == 1;
        return {~b6, b6, v};
    endfunction

    function automatic logic [7:0] m_odd7(input logic [6:0] w);
        int ones;
        ones = 0;
        for (int i = 0; i < 7; i++) ones += int'(w[i]);
        return {((ones % 2) == 0), w};
    endfunction

    function automatic logic [7:0] pay(input int seed, input int i);
        return 8'(seed + 37 * i);
    endfunction

    task automatic build_exp(input int len, input int seed, input bit fid,
                             input logic [8:0] line, input logic [3:0] kind,
                             input logic [5:0] tag);
        int n;
        int dc;
        int k;
        logic [7:0] b;
        n  = (len > KEEP) ? KEEP : len;
        dc = (2 + 2 * n + 3) / 4;
        k  = 0;
        expb[k++] = 8'h00; expb[k++] = 8'hFF; expb[k++] = 8'hFF;
        expb[k++] = m_even6(tag);
        expb[k++] = m_even6(6'(dc));
        expb[k++] = m_odd7({fid, line[8:3]});
        expb[k++] = m_odd7({line[2:0], kind});
        for (int i = 0; i < n; i++) begin
            b = pay(seed, i);
            expb[k++] = m_even6({b[3:0], 2'b11});
            expb[k++] = m_even6({b[7:4], 2'b11});
        end
        while (k < 5 + 4 * dc) expb[k++] = 8'h00;
        expb[k++] = EOD;
        exp_n   = k;
        exp_pay = n;
    endtask

    function automatic string tag_of(input int p);
        if (p <= 3) return "R1";
        if (p == 4) return "R3";
        if (p == 5) return "R4 R11";
        if (p == 6) return "R5 R11";
        if (p < 7 + 2 * exp_pay) return "R6";
        if (p < exp_n - 1) return "R7";
        return "R8";
    endfunction

    task automatic send(input int len, input int seed, input bit fid,
                        input logic [8:0] line, input logic [3:0] kind,
                        input logic [5:0] tag);
        field_id = fid; line_no = line; data_kind = kind; stream_tag = tag;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = pay(seed, i);
            in_last  = (i == len - 1);
            @(posedge clk);
        end
        #1;
        in_valid = 1'b0; in_last = 1'b0;
        // R11: scramble sideband right after the last byte is taken
        field_id = ~fid; line_no = ~line; data_kind = ~kind; stream_tag = ~tag;
        cap_n = 0; eop_seen = 1'b0;
        @(negedge clk);
        chk(!out_valid && !in_ready, "R13 R9", {out_valid, in_ready}, 0);
        @(negedge clk);
        chk(out_valid && out_sop, "R13", {out_valid, out_sop}, 3);
    endtask

    task automatic wait_done;
        for (int c = 0; c < 200 && !eop_seen; c++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic compare_stream;
        int bad;
        bad = -1;
        chk(cap_n == exp_n, "R8", cap_n, exp_n);
        for (int p = 0; p < exp_n && p < 64; p++) begin
            if (bad < 0 && cap[p] !== expb[p]) bad = p;
        end
        if (bad >= 0) chk(1'b0, tag_of(bad), cap[bad], expb[bad]);
        else          chk(1'b1, "R6", 0, 0);
    endtask

    task automatic report;
        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            report();
        end
    end

    initial begin
        logic [39:0] v;
        int          ones;
        rst = 1'b1; in_valid = 1'b0; in_data = 8'h00; in_last = 1'b0;
        field_id = 1'b0; line_no = '0; data_kind = '0; stream_tag = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: idle during reset
        chk(!out_valid && in_ready, "R12", {out_valid, in_ready}, 1);
        rst = 1'b0;

        for (int t = 0; t < 8; t++) begin
            v = VECS[t];
            build_exp(int'(v[39:32]), int'(v[31:24]), v[10], v[23:15], v[14:11], v[9:4]);
            send(int'(v[39:32]), int'(v[31:24]), v[10], v[23:15], v[14:11], v[9:4]);
            wait_done();
            compare_stream();
            ones = 0;
            for (int i = 0; i < 7; i++) ones += int'(cap[3][i]);
            chk((ones % 2) == 0, "R2", cap[3], expb[3]);
            if (int'(v[39:32]) > KEEP) begin
                // R10: clamp at 11 words, extra bytes dropped
                chk(cap[4] == m_even6(6'd11), "R10", cap[4], m_even6(6'd11));
                chk(cap_n == 6 + 44, "R10", cap_n, 50);
            end
            repeat (2) @(negedge clk);
        end

        // R9: input offered during emission is ignored
        build_exp(3, 8'h44, 1'b1, 9'd100, 4'h6, 6'h19);
        send(3, 8'h44, 1'b1, 9'd100, 4'h6, 6'h19);
        in_valid = 1'b1; in_data = 8'hEE; in_last = 1'b1;
        chk(!in_ready, "R9", in_ready, 0);
        repeat (4) @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        wait_done();
        compare_stream();
        repeat (6) @(negedge clk);
        chk(cap_n == exp_n && !out_valid && in_ready, "R9", cap_n, exp_n);
        build_exp(2, 8'h61, 1'b0, 9'd33, 4'h2, 6'h07);
        send(2, 8'h61, 1'b0, 9'd33, 4'h2, 6'h07);
        wait_done();
        compare_stream();

        // R12: reset in the middle of a packet
        repeat (2) @(negedge clk);
        send(5, 8'h90, 1'b0, 9'd12, 4'h1, 6'h11);
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(!out_valid && in_ready, "R12", {out_valid, in_ready}, 1);
        build_exp(1, 8'h7B, 1'b1, 9'd450, 4'hE, 6'h2C);
        send(1, 8'h7B, 1'b1, 9'd450, 4'hE, 6'h2C);
        wait_done();
        compare_stream();
        chk(cap[4] == m_even6(6'd1), "R12 R3", cap[4], m_even6(6'd1));

        report();
    end

endmodule